// File: doc/BRIEF.md
# Unprivileged byte load address unit

This block executes one unprivileged byte load at a time. It accepts an operation that is already decoded, together with the base and index register values it needs. It forms the byte address and issues one read request to memory. That request always carries a user-privilege attribute, whatever mode the processor is in. When the byte comes back, the block zero-extends it to a register-wide word and writes it to the destination register. In the same cycle, for the post-indexed forms, it sends an updated base value back to the base register.

Three operation forms are supported:
- Form 0 is post-indexed with a 12-bit immediate offset.
- Form 1 is post-indexed with a shifted index register as the offset.
- Form 2 is an offset form with an 8-bit immediate. It always adds and never writes back.

Condition evaluation happens outside the block and arrives as a single pass bit. An operation that fails its condition is accepted and dropped. Register combinations whose result is unpredictable still run to completion. For those, a flag is raised in the same cycle as the register writes.

The block has three streams, all using valid/ready:
- **Operation stream.** `op_ready` is high only while the block is idle. The operation fields, `base_val` and `index_val` are sampled in the cycle where `op_valid` and `op_ready` are both high, and they are not needed afterwards.
- **Read request.** Once `mem_req_valid` rises, it stays high with a stable address until `mem_req_ready` is seen.
- **Read response.** `mem_rsp_ready` rises only after the request has been taken. It stays high until `mem_rsp_valid` arrives.

Only one operation is in flight at a time.

Top module: `ubyte_load_agu`

## Requirements
- R1: Form 0 (`op_form`=0) zero-extends the 12-bit `op_imm` into the offset. It requests the unmodified base value and asserts `wb_we` with `wb_data` = base±offset and `wb_idx` = `op_rn`.
- R2: Form 1 (`op_form`=1) uses the shifted `index_val` as its offset. It requests the unmodified base value and writes back base±offset to `op_rn`.
- R3: The shift in form 1 is selected by `op_shtype`: 0 is shift-left, 1 is logical shift-right, 2 is arithmetic shift-right, 3 is rotate-right. An `op_shamt` of 0 has a special meaning for three of them. For logical shift-right it means a shift by 32 (result 0). For arithmetic shift-right it means a shift by 32 (every bit equals the sign). For rotate-right it means a one-bit rotate with `op_carry` entering bit 31. For shift-left it means no shift.
- R4: Form 2 (`op_form`=2, with code 3 treated the same) requests base plus `op_imm[7:0]` zero-extended. It ignores `op_up` and never asserts `wb_we`.
- R5: In forms 0 and 1, `op_up`=1 adds the offset to the base and `op_up`=0 subtracts it, modulo 2^32.
- R6: When the response is accepted, `rd_we` pulses with `rd_idx` = `op_rt` and `rd_data` = {24 zeros, `mem_rsp_data`}. `wb_we` can be high only in that same cycle.
- R7: Every request has `mem_req_user`=1 and `mem_req_read`=1, regardless of `op_hyp`.
- R8: `unpred` is high together with `rd_we` when the operation was unpredictable. Any form is unpredictable when `op_hyp`=1. Forms 0 and 1 are also unpredictable when `op_rt`=15, `op_rn`=15 or `op_rn`=`op_rt`, and form 1 additionally when `op_rm`=15. Form 2 is also unpredictable when `op_rt`=15.
- R9: An operation accepted with `op_cond_pass`=0 produces no request, no `rd_we` and no `wb_we`, and the block is ready again in the next cycle.
- R10: The handshake rules are as follows. `op_ready` is high only while idle. The request stays valid with a stable address until it is accepted. `mem_rsp_ready` is high only after the request is accepted and never together with `mem_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation taken this cycle |
| op_form | input | 2 | 0 imm12 post-index, 1 register post-index, 2/3 imm8 offset |
| op_cond_pass | input | 1 | Condition passed |
| op_up | input | 1 | 1 add offset, 0 subtract (forms 0 and 1) |
| op_rt | input | 4 | Destination register index |
| op_rn | input | 4 | Base register index |
| op_rm | input | 4 | Index register number |
| op_imm | input | 12 | Immediate offset (form 2 uses bits 7:0) |
| op_shtype | input | 2 | Shift kind for form 1 |
| op_shamt | input | 5 | Shift amount for form 1 |
| op_carry | input | 1 | Carry flag for rotate-with-extend |
| op_hyp | input | 1 | Processor at hypervisor level |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 32 | Byte address |
| mem_req_user | output | 1 | User-privilege access attribute |
| mem_req_read | output | 1 | Read strobe |
| mem_rsp_valid | input | 1 | Response byte valid |
| mem_rsp_ready | output | 1 | Response accepted |
| mem_rsp_data | input | 8 | Loaded byte |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | 4 | Destination index |
| rd_data | output | 32 | Zero-extended byte |
| wb_we | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | Updated base value |
| unpred | output | 1 | Operation was unpredictable |

## Verification
Forms, directions, shift kinds and amounts are drawn at random, together with base and index values whose top bit is often set. These operations are mixed with directed cases at the edges:
- a zero shift amount for each shift kind;
- a subtraction that wraps;
- the largest immediates;
- form 2 offered with `op_up`=0.

Between them, these cases tell apart a post-indexed address from a pre-computed one, addition from subtraction, and a 12-bit immediate from an 8-bit one. They also separate logical from arithmetic right shifts, and rotate-with-extend from a plain rotate.

Register-index patterns cover each unpredictable combination separately, including a base of 15 in form 2, which must not raise the flag. Random delays on both memory handshakes show that the request holds steady and that no register write leaks out before the response is taken.

// File: rtl/uload_pkg.sv
package uload_pkg;

  typedef enum logic [1:0] {
    FORM_IMM_POST = 2'd0,
    FORM_REG_POST = 2'd1,
    FORM_IMM_OFS  = 2'd2,
    FORM_IMM_OFS2 = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } state_e;

  function automatic logic form_is_post(input logic [1:0] f);
    return (f == FORM_IMM_POST) || (f == FORM_REG_POST);
  endfunction

endpackage

// File: rtl/uload_shifter.sv
module uload_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [1:0]        kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              carry,
  output logic [DATA_W-1:0] res
);
  import uload_pkg::*;

  logic [2*DATA_W-1:0] doubled;
  logic [2*DATA_W-1:0] rotated;
  logic signed [DATA_W-1:0] sval;

  assign doubled = {val, val};
  assign rotated = doubled >> amt;
  assign sval    = $signed(val);

  always_comb begin
    res = val;
    unique case (shift_e'(kind))
      SH_LSL: res = val << amt;
      SH_LSR: res = (amt == '0) ? '0 : (val >> amt);
      SH_ASR: res = (amt == '0) ? {DATA_W{val[DATA_W-1]}} : DATA_W'(sval >>> amt);
      SH_ROR: res = (amt == '0) ? {carry, val[DATA_W-1:1]} : rotated[DATA_W-1:0];
      default: res = val;
    endcase
  end

endmodule

// File: rtl/uload_addr.sv
module uload_addr #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              up,
  input  logic              post,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] next_base
);
  logic [DATA_W-1:0] opnd;

  // single adder: subtraction through inversion plus carry-in
  assign opnd      = up ? offset : ~offset;
  assign next_base = base + opnd + {{(DATA_W-1){1'b0}}, ~up};
  assign addr      = post ? base : next_base;

endmodule

// File: rtl/uload_check.sv
module uload_check #(
  parameter int REG_W = 4
) (
  input  logic [1:0]       form,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rn,
  input  logic [REG_W-1:0] rm,
  input  logic             hyp,
  output logic             flag
);
  import uload_pkg::*;

  localparam logic [REG_W-1:0] PC_IDX = {REG_W{1'b1}};

  logic rt_pc, rn_pc, rm_pc, overlap;

  assign rt_pc   = (rt == PC_IDX);
  assign rn_pc   = (rn == PC_IDX);
  assign rm_pc   = (rm == PC_IDX);
  assign overlap = (rn == rt);

  always_comb begin
    unique case (form_e'(form))
      FORM_IMM_POST: flag = rt_pc | rn_pc | overlap;
      FORM_REG_POST: flag = rt_pc | rn_pc | overlap | rm_pc;
      default:       flag = rt_pc;
    endcase
    flag = flag | hyp;
  end

endmodule

// File: rtl/ubyte_load_agu.sv
module ubyte_load_agu #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int REG_W   = 4,
  parameter int IMM_W   = 12,
  parameter int SIMM_W  = 8,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [1:0]         op_form,
  input  logic               op_cond_pass,
  input  logic               op_up,
  input  logic [REG_W-1:0]   op_rt,
  input  logic [REG_W-1:0]   op_rn,
  input  logic [REG_W-1:0]   op_rm,
  input  logic [IMM_W-1:0]   op_imm,
  input  logic [1:0]         op_shtype,
  input  logic [SHAMT_W-1:0] op_shamt,
  input  logic               op_carry,
  input  logic               op_hyp,
  input  logic [DATA_W-1:0]  base_val,
  input  logic [DATA_W-1:0]  index_val,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [DATA_W-1:0]  mem_req_addr,
  output logic               mem_req_user,
  output logic               mem_req_read,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [BYTE_W-1:0]  mem_rsp_data,
  output logic               rd_we,
  output logic [REG_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               wb_we,
  output logic [REG_W-1:0]   wb_idx,
  output logic [DATA_W-1:0]  wb_data,
  output logic               unpred
);
  import uload_pkg::*;

  localparam logic [REG_W-1:0] PC_IDX = {REG_W{1'b1}};

  state_e state_q;

  logic              accept, go;
  logic              post_now, up_now, unpred_now;
  logic [DATA_W-1:0] shifted, offset, addr_now, nb_now;

  logic [DATA_W-1:0] addr_q, nb_q;
  logic [REG_W-1:0]  rt_q, rn_q;
  logic              post_q, unpred_q;
  logic              rsp_take;

  // ---------------- operand stage ----------------
  uload_shifter #(.DATA_W(DATA_W), .AMT_W(SHAMT_W)) u_shift (
    .val   (index_val),
    .kind  (op_shtype),
    .amt   (op_shamt),
    .carry (op_carry),
    .res   (shifted)
  );

  always_comb begin
    unique case (form_e'(op_form))
      FORM_IMM_POST: offset = DATA_W'(op_imm);
      FORM_REG_POST: offset = shifted;
      default:       offset = DATA_W'(op_imm[SIMM_W-1:0]);
    endcase
  end

  assign post_now = form_is_post(op_form);
  assign up_now   = post_now ? op_up : 1'b1;

  uload_addr #(.DATA_W(DATA_W)) u_addr (
    .base      (base_val),
    .offset    (offset),
    .up        (up_now),
    .post      (post_now),
    .addr      (addr_now),
    .next_base (nb_now)
  );

  uload_check #(.REG_W(REG_W)) u_check (
    .form (op_form),
    .rt   (op_rt),
    .rn   (op_rn),
    .rm   (op_rm),
    .hyp  (op_hyp),
    .flag (unpred_now)
  );

  // ---------------- control ----------------
  assign op_ready = (state_q == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign go       = accept && op_cond_pass;
  assign rsp_take = (state_q == ST_RSP) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go)            state_q <= ST_REQ;
        ST_REQ:  if (mem_req_ready) state_q <= ST_RSP;
        ST_RSP:  if (mem_rsp_valid) state_q <= ST_IDLE;
        default:                    state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      nb_q     <= '0;
      rt_q     <= '0;
      rn_q     <= '0;
      post_q   <= 1'b0;
      unpred_q <= 1'b0;
    end else if (go) begin
      addr_q   <= addr_now;
      nb_q     <= nb_now;
      rt_q     <= op_rt;
      rn_q     <= op_rn;
      post_q   <= post_now;
      unpred_q <= unpred_now;
    end
  end

  // ---------------- memory side ----------------
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_user  = 1'b1;
  assign mem_req_read  = mem_req_valid;
  assign mem_rsp_ready = (state_q == ST_RSP);

  // ---------------- register writes ----------------
  assign rd_we   = rsp_take;
  assign rd_idx  = rt_q;
  assign rd_data = {{(DATA_W-BYTE_W){1'b0}}, mem_rsp_data};
  assign wb_we   = rsp_take && post_q;
  assign wb_idx  = rn_q;
  assign wb_data = nb_q;
  assign unpred  = rsp_take && unpred_q;

  // ---------------- assertions ----------------
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid && !op_ready);

  p_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_user && mem_req_read);

  p_cond_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !op_cond_pass |=> !mem_req_valid && op_ready && !rd_we);

  p_unpred_rt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op_rt == PC_IDX || op_hyp) |-> unpred_now);

  p_wb_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> rd_we && mem_rsp_ready);

  p_req_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> mem_req_valid);

endmodule

// File: tb/test_ubyte_load_agu.sv
module test_ubyte_load_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_form = '0;
  logic        op_cond_pass = 1'b0;
  logic        op_up = 1'b0;
  logic [3:0]  op_rt = '0, op_rn = '0, op_rm = '0;
  logic [11:0] op_imm = '0;
  logic [1:0]  op_shtype = '0;
  logic [4:0]  op_shamt = '0;
  logic        op_carry = 1'b0;
  logic        op_hyp = 1'b0;
  logic [31:0] base_val = '0, index_val = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_req_user, mem_req_read;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [7:0]  mem_rsp_data = '0;
  logic        rd_we, wb_we, unpred;
  logic [3:0]  rd_idx, wb_idx;
  logic [31:0] rd_data, wb_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ubyte_load_agu i_ubyte_load_agu (
    .clk, .rst_n, .op_valid, .op_ready, .op_form, .op_cond_pass, .op_up,
    .op_rt, .op_rn, .op_rm, .op_imm, .op_shtype, .op_shamt, .op_carry, .op_hyp,
    .base_val, .index_val, .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_req_user, .mem_req_read, .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .rd_we, .rd_idx, .rd_data, .wb_we, .wb_idx, .wb_data, .unpred
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_offset(input logic [1:0] f, input logic [11:0] imm,
      input logic [1:0] st, input logic [4:0] sa, input logic [31:0] ix, input logic c);
    logic [63:0] dd;
    if (f == 2'd0) return {20'd0, imm};
    if (f != 2'd1) return {24'd0, imm[7:0]};
    case (st)
      2'd0: return ix << sa;
      2'd1: return (sa == 0) ? 32'd0 : ix >> sa;
      2'd2: return (sa == 0) ? (ix[31] ? 32'hFFFF_FFFF : 32'd0) : 32'($signed(ix) >>> sa);
      default: begin
        if (sa == 0) return {c, ix[31:1]};
        dd = {ix, ix} >> sa;
        return dd[31:0];
      end
    endcase
  endfunction

  function automatic logic m_unpred(input logic [1:0] f, input logic [3:0] t,
      input logic [3:0] n, input logic [3:0] m, input logic h);
    if (h) return 1'b1;
    if (f == 2'd0) return (t == 15) || (n == 15) || (n == t);
    if (f == 2'd1) return (t == 15) || (n == 15) || (n == t) || (m == 15);
    return t == 15;
  endfunction

  task automatic run_op(input logic [1:0] f, input logic pass, input logic up,
      input logic [3:0] t, input logic [3:0] n, input logic [3:0] m,
      input logic [11:0] imm, input logic [1:0] st, input logic [4:0] sa,
      input logic c, input logic h, input logic [31:0] b, input logic [31:0] ix,
      input int dreq, input int drsp, input logic [7:0] byt);
    logic post;
    logic [31:0] off, nb, ad;
    post = (f == 2'd0) || (f == 2'd1);
    off  = m_offset(f, imm, st, sa, ix, c);
    nb   = (post && !up) ? b - off : b + off;
    ad   = post ? b : nb;

    @(negedge clk);
    op_valid = 1'b1; op_form = f; op_cond_pass = pass; op_up = up;
    op_rt = t; op_rn = n; op_rm = m; op_imm = imm; op_shtype = st;
    op_shamt = sa; op_carry = c; op_hyp = h; base_val = b; index_val = ix;
    #1 chk(32'(op_ready), 32'd1, "R10 op_ready idle");
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; base_val = $urandom; index_val = $urandom;
    #1;
    if (!pass) begin
      chk(32'(mem_req_valid), 32'd0, "R9 no request");
      chk(32'(rd_we | wb_we), 32'd0, "R9 no writes");
      chk(32'(op_ready), 32'd1, "R9 ready again");
      return;
    end
    chk(32'(op_ready), 32'd0, "R10 busy");
    for (int k = 0; k <= dreq; k++) begin
      if (k != 0) begin @(negedge clk); #1; end
      mem_req_ready = (k == dreq);
      #1;
      chk(32'(mem_req_valid), 32'd1, "R10 request held");
      chk(mem_req_addr, ad, "R1/R2/R4/R5 address");
      chk(32'(mem_req_user & mem_req_read), 32'd1, "R7 user read");
      chk(32'(mem_rsp_ready | rd_we), 32'd0, "R10 no rsp ready during request");
      @(posedge clk);
    end
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int k = 0; k <= drsp; k++) begin
      if (k != 0) @(negedge clk);
      mem_rsp_valid = (k == drsp);
      mem_rsp_data = (k == drsp) ? byt : 8'($urandom);
      #1;
      chk(32'(mem_rsp_ready), 32'd1, "R10 rsp ready");
      chk(32'(mem_req_valid), 32'd0, "R10 request dropped");
      if (k != drsp) begin
        chk(32'(rd_we | wb_we | unpred), 32'd0, "R6 no early write");
      end else begin
        chk(32'(rd_we), 32'd1, "R6 rd_we");
        chk(32'(rd_idx), 32'(t), "R6 rd_idx");
        chk(rd_data, {24'd0, byt}, "R6 zero extend");
        chk(32'(wb_we), 32'(post), "R1/R2/R4 wb_we");
        if (post) begin
          chk(32'(wb_idx), 32'(n), "R1/R2 wb_idx");
          chk(wb_data, nb, "R1/R2/R3/R5 wb_data");
        end
        chk(32'(unpred), 32'(m_unpred(f, t, n, m, h)), "R8 unpred");
      end
      @(posedge clk);
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    #1 chk(32'(rd_we | wb_we), 32'd0, "R6 single pulse");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(32'(mem_req_valid), 32'd0, "R10 reset no request");
    chk(32'(rd_we | wb_we | unpred), 32'd0, "R6 reset no writes");
    chk(32'(op_ready), 32'd1, "R10 reset ready");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 largest immediate, add and subtract with wrap (R5)
    run_op(2'd0, 1, 1, 4'd1, 4'd2, 4'd0, 12'hFFF, 2'd0, 5'd0, 0, 0, 32'h1000_0000, 0, 0, 0, 8'hA5);
    run_op(2'd0, 1, 0, 4'd1, 4'd2, 4'd0, 12'h010, 2'd0, 5'd0, 0, 0, 32'h0000_0004, 0, 1, 2, 8'hFF);
    // R3 shift corners in form 1 (R2)
    run_op(2'd1, 1, 1, 4'd3, 4'd4, 4'd5, 12'h0, 2'd0, 5'd0, 0, 0, 32'h100, 32'h8000_0011, 0, 0, 8'h01);
    run_op(2'd1, 1, 1, 4'd3, 4'd4, 4'd5, 12'h0, 2'd1, 5'd0, 0, 0, 32'h100, 32'h8000_0011, 0, 0, 8'h02);
    run_op(2'd1, 1, 0, 4'd3, 4'd4, 4'd5, 12'h0, 2'd2, 5'd0, 0, 0, 32'h100, 32'h8000_0011, 2, 0, 8'h03);
    run_op(2'd1, 1, 1, 4'd3, 4'd4, 4'd5, 12'h0, 2'd3, 5'd0, 1, 0, 32'h100, 32'h0000_0003, 0, 1, 8'h04);
    run_op(2'd1, 1, 1, 4'd3, 4'd4, 4'd5, 12'h0, 2'd3, 5'd4, 0, 0, 32'h100, 32'h1234_5678, 0, 0, 8'h05);
    run_op(2'd1, 1, 1, 4'd3, 4'd4, 4'd5, 12'h0, 2'd2, 5'd31, 0, 0, 0, 32'h8000_0000, 0, 0, 8'h06);
    // R4 form 2 ignores up, no writeback; base 15 not flagged
    run_op(2'd2, 1, 0, 4'd6, 4'd15, 4'd0, 12'hFAB, 2'd0, 5'd0, 0, 0, 32'hFFFF_FFF0, 0, 0, 0, 8'h80);
    run_op(2'd3, 1, 1, 4'd6, 4'd6, 4'd0, 12'h0FF, 2'd0, 5'd0, 0, 0, 32'h20, 0, 1, 1, 8'h7F);
    // R8 unpredictable combinations
    run_op(2'd2, 1, 1, 4'd15, 4'd1, 4'd0, 12'h1, 2'd0, 5'd0, 0, 0, 32'h40, 0, 0, 0, 8'h11);
    run_op(2'd0, 1, 1, 4'd7, 4'd7, 4'd0, 12'h1, 2'd0, 5'd0, 0, 0, 32'h40, 0, 0, 0, 8'h12);
    run_op(2'd0, 1, 1, 4'd7, 4'd15, 4'd0, 12'h1, 2'd0, 5'd0, 0, 0, 32'h40, 0, 0, 0, 8'h13);
    run_op(2'd1, 1, 1, 4'd7, 4'd8, 4'd15, 12'h0, 2'd0, 5'd1, 0, 0, 32'h40, 32'h2, 0, 0, 8'h14);
    run_op(2'd0, 1, 1, 4'd7, 4'd8, 4'd15, 12'h1, 2'd0, 5'd0, 0, 0, 32'h40, 0, 0, 0, 8'h15);
    run_op(2'd2, 1, 1, 4'd1, 4'd2, 4'd0, 12'h1, 2'd0, 5'd0, 0, 1, 32'h40, 0, 0, 0, 8'h16); // R7 user under hyp
    // R9 condition fail
    run_op(2'd0, 0, 1, 4'd1, 4'd2, 4'd0, 12'h1, 2'd0, 5'd0, 0, 0, 32'h40, 0, 0, 0, 8'h00);
    run_op(2'd1, 0, 0, 4'd1, 4'd2, 4'd3, 12'h0, 2'd1, 5'd3, 0, 0, 32'h40, 32'h55, 0, 0, 8'h00);

    for (int i = 0; i < 400; i++) begin
      run_op(2'($urandom), ($urandom % 8) != 0, 1'($urandom), 4'($urandom), 4'($urandom),
             4'($urandom), 12'($urandom), 2'($urandom), 5'($urandom), 1'($urandom),
             ($urandom % 10) == 0, $urandom, $urandom, $urandom % 4, $urandom % 4, 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule